// File: doc/BRIEF.md
# Grouped Vertical Clock Pattern Sequencer

This block produces the vertical transfer clocks of an image sensor for the length of a vertical sequence. It has 24 clock outputs and four shared pattern engines (groups A to D). Each output is tied to one engine by a 2-bit code in a packed map. Each engine waits in the line until the pixel counter reaches its start position. It then plays one stored toggle pattern for a programmed number of repetitions. Before the first toggle, every output takes a start level from a polarity vector that belongs to its group.

A sequence-start strobe loads the start levels and arms the engines. Each later line-start strobe arms the engines again with the repetition counts presented at that moment, and the output levels carry on from the previous line. The repetition counts come from an external per-line selector. The final repetition can use its own length. An extra closing toggle can follow the final repetition. A merge mode drives every output from engine A, which then reacts to the toggle positions of all four selected patterns. All interfaces are plain control and configuration pins: there is no data stream, so no valid/ready handshake and no back-pressure. Configuration is expected to stay stable while a sequence runs, except for the repetition counts. Those are sampled at each arm strobe.

Top module: `vseq_clock_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released until the first sequence start, all 24 clock outputs are 0 and `seq_done` is 0.
- R2: In the cycle after `seq_start`, output i (0-based) takes bit `i` of the start-polarity vector of its group. Group g's vector is `start_pol[24g+23:24g]`. The group code of output i is `grp_map_lo[2i+1:2i]` for i<12 and `grp_map_hi[2(i-12)+1:2(i-12)]` for i>=12, with codes 0=A, 1=B, 2=C, 3=D.
- R3: After being armed, engine g enters its first repetition on the first cycle in which `pix_cnt` equals its start position, with its position counter at 0. The counter then advances by one per clock. Every output of the group inverts in the cycle after the counter equals either toggle position of the selected pattern.
- R4: Engine g runs `rep_cnt` repetitions. Each repetition lasts `pat_len` cycles, and a length of 0 acts as 1. When `last_len_en[g]` is 1 (group A in bit 0), the final repetition lasts `last_len` cycles instead.
- R5: When `tail_en[g]` is 1, the counter restarts at 0 after the final repetition. The group's outputs invert once, in the cycle after the counter equals `tail_pos`. The engine then finishes.
- R6: A repetition count of 0 makes the engine finish at arm time with no toggles, and its outputs keep their level.
- R7: When `merge_mode` is 1, every output uses group A's polarity, start, lengths, repetitions and tail settings. Engine A toggles on the positions of all four selected patterns, and engines B to D are armed with zero repetitions. Any other code, including the reserved codes 2 and 15, gives normal grouped operation.
- R8: `seq_done` is 1 while a sequence is active and every engine has finished. A finished engine produces no more toggles, so outputs hold their levels. `seq_done` falls only in the cycle after a `seq_start` or an accepted `line_start`.
- R9: `line_start` after a sequence has started re-arms all engines with the current `rep_cnt` and leaves the outputs unchanged. A `line_start` before the first `seq_start` has no effect.
- R10: A pulse on `pat_wr_en` stores both toggle positions into pattern entry `pat_wr_addr`. Engines selecting that entry use the new positions from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_cnt | input | 13 | Pixel position within the line |
| line_start | input | 1 | Line strobe, re-arms the engines |
| seq_start | input | 1 | Sequence strobe, loads start levels and arms the engines |
| grp_map_lo | input | 24 | Group codes of outputs 0..11, 2 bits each |
| grp_map_hi | input | 24 | Group codes of outputs 12..23, 2 bits each |
| start_pol | input | 96 | Start-level vector per group, 24 bits each, A lowest |
| start_pos | input | 52 | Start pixel per group, 13 bits each |
| pat_len | input | 52 | Repetition length per group |
| last_len | input | 52 | Final repetition length per group |
| last_len_en | input | 4 | Final-length enable per group, A in bit 0 |
| tail_en | input | 4 | Closing toggle enable per group, A in bit 0 |
| tail_pos | input | 52 | Closing toggle position per group |
| pat_sel | input | 20 | Stored pattern index per group, 5 bits each |
| rep_cnt | input | 52 | Per-line repetition count per group |
| merge_mode | input | 4 | 1 merges all groups into A, other codes normal |
| pat_wr_en | input | 1 | Pattern store write strobe |
| pat_wr_addr | input | 5 | Pattern entry to write |
| pat_wr_tog_a | input | 13 | First toggle position written |
| pat_wr_tog_b | input | 13 | Second toggle position written |
| vclk_out | output | 24 | Vertical clock levels |
| seq_done | output | 1 | All engines in use have finished |

## Verification
An engine whose counter or repetition index is wrong shows up at the outputs as a group edge that comes too early, too late, or one too many. This appears within one pattern length of the first misstep, and every output mapped to that group shows the same error. A wrong finish state shows up in `seq_done` on the very next cycle. A corrupted map or polarity entry shows up on a single output pin one cycle after `seq_start`. The bench therefore compares all outputs against its reference model on every clock, so the first cycle of divergence is the one reported.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_WAIT,
    ENG_RUN,
    ENG_TAIL,
    ENG_FIN
  } eng_state_t;

  localparam int unsigned MERGE_CODE = 1;

endpackage

// File: rtl/vseq_pattern_store.sv
module vseq_pattern_store #(
  parameter int NUM_PAT = 32,
  parameter int POS_W   = 13,
  parameter int NUM_RD  = 4,
  localparam int SEL_W  = $clog2(NUM_PAT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_addr,
  input  logic [POS_W-1:0]        wr_tog_a,
  input  logic [POS_W-1:0]        wr_tog_b,
  input  logic [NUM_RD*SEL_W-1:0] rd_sel,
  output logic [NUM_RD*POS_W-1:0] rd_tog_a,
  output logic [NUM_RD*POS_W-1:0] rd_tog_b
);

  logic [POS_W-1:0] mem_a [NUM_PAT];
  logic [POS_W-1:0] mem_b [NUM_PAT];

  // Entries reset to the top position so an unwritten pattern never fires early.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_PAT; e++) begin
        mem_a[e] <= '1;
        mem_b[e] <= '1;
      end
    end else if (wr_en && (int'(wr_addr) < NUM_PAT)) begin
      mem_a[wr_addr] <= wr_tog_a;
      mem_b[wr_addr] <= wr_tog_b;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    logic [SEL_W-1:0] sel;
    assign sel = rd_sel[r*SEL_W +: SEL_W];
    assign rd_tog_a[r*POS_W +: POS_W] = (int'(sel) < NUM_PAT) ? mem_a[sel] : '1;
    assign rd_tog_b[r*POS_W +: POS_W] = (int'(sel) < NUM_PAT) ? mem_b[sel] : '1;
  end

endmodule

// File: rtl/vseq_group_engine.sv
module vseq_group_engine
  import vseq_pkg::*;
#(
  parameter int POS_W   = 13,
  parameter int REP_W   = 13,
  parameter int NUM_TOG = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic [REP_W-1:0]         rep_cnt,
  input  logic [POS_W-1:0]         start_pos,
  input  logic [POS_W-1:0]         pat_len,
  input  logic [POS_W-1:0]         last_len,
  input  logic                     last_len_en,
  input  logic                     tail_en,
  input  logic [POS_W-1:0]         tail_pos,
  input  logic [POS_W-1:0]         pix_cnt,
  input  logic [NUM_TOG*POS_W-1:0] tog_pos,
  input  logic [NUM_TOG-1:0]       tog_use,
  output logic                     toggle,
  output logic                     finished
);

  eng_state_t       state_q;
  logic [POS_W-1:0] pos_q;
  logic [REP_W-1:0] rep_idx_q;
  logic [REP_W-1:0] rep_tot_q;

  logic             on_last;
  logic [POS_W-1:0] cur_len;
  logic             rep_end;
  logic             tog_hit;
  logic             tail_hit;

  assign on_last = (rep_idx_q == rep_tot_q - REP_W'(1));
  assign cur_len = (last_len_en && on_last) ? last_len : pat_len;
  // A zero length also ends the repetition after one cycle.
  assign rep_end = ({1'b0, pos_q} + (POS_W+1)'(1)) >= {1'b0, cur_len};
  assign tail_hit = (pos_q == tail_pos);

  always_comb begin
    tog_hit = 1'b0;
    for (int k = 0; k < NUM_TOG; k++) begin
      if (tog_use[k] && (tog_pos[k*POS_W +: POS_W] == pos_q)) tog_hit = 1'b1;
    end
  end

  assign toggle   = ((state_q == ENG_RUN) && tog_hit) ||
                    ((state_q == ENG_TAIL) && tail_hit);
  assign finished = (state_q == ENG_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ENG_IDLE;
      pos_q     <= '0;
      rep_idx_q <= '0;
      rep_tot_q <= '0;
    end else if (arm) begin
      rep_tot_q <= rep_cnt;
      rep_idx_q <= '0;
      pos_q     <= '0;
      state_q   <= (rep_cnt == '0) ? ENG_FIN : ENG_WAIT;
    end else begin
      unique case (state_q)
        ENG_WAIT: begin
          if (pix_cnt == start_pos) begin
            state_q <= ENG_RUN;
            pos_q   <= '0;
          end
        end
        ENG_RUN: begin
          if (rep_end) begin
            pos_q <= '0;
            if (on_last) begin
              state_q <= tail_en ? ENG_TAIL : ENG_FIN;
            end else begin
              rep_idx_q <= rep_idx_q + REP_W'(1);
            end
          end else begin
            pos_q <= pos_q + POS_W'(1);
          end
        end
        ENG_TAIL: begin
          if (tail_hit) state_q <= ENG_FIN;
          else          pos_q   <= pos_q + POS_W'(1);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vseq_output_map.sv
module vseq_output_map #(
  parameter int NUM_OUT = 24,
  parameter int NUM_GRP = 4,
  localparam int GSEL_W = $clog2(NUM_GRP)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       merge,
  input  logic [NUM_OUT*GSEL_W-1:0]  grp_sel,
  input  logic [NUM_GRP*NUM_OUT-1:0] start_pol,
  input  logic [NUM_GRP-1:0]         grp_toggle,
  output logic [NUM_OUT-1:0]         level
);

  logic [NUM_OUT-1:0] level_q;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic [GSEL_W-1:0] grp;
    assign grp = merge ? '0 : grp_sel[i*GSEL_W +: GSEL_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                level_q[i] <= 1'b0;
      else if (load)             level_q[i] <= start_pol[int'(grp)*NUM_OUT + i];
      else if (grp_toggle[grp])  level_q[i] <= ~level_q[i];
    end
  end

  assign level = level_q;

endmodule

// File: rtl/vseq_clock_sequencer.sv
module vseq_clock_sequencer
  import vseq_pkg::*;
#(
  parameter int NUM_OUT = 24,
  parameter int NUM_GRP = 4,
  parameter int POS_W   = 13,
  parameter int REP_W   = 13,
  parameter int NUM_PAT = 32,
  parameter int MODE_W  = 4,
  localparam int SEL_W  = $clog2(NUM_PAT),
  localparam int GSEL_W = $clog2(NUM_GRP),
  localparam int MAP_W  = (NUM_OUT / 2) * GSEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [POS_W-1:0]           pix_cnt,
  input  logic                       line_start,
  input  logic                       seq_start,
  input  logic [MAP_W-1:0]           grp_map_lo,
  input  logic [MAP_W-1:0]           grp_map_hi,
  input  logic [NUM_GRP*NUM_OUT-1:0] start_pol,
  input  logic [NUM_GRP*POS_W-1:0]   start_pos,
  input  logic [NUM_GRP*POS_W-1:0]   pat_len,
  input  logic [NUM_GRP*POS_W-1:0]   last_len,
  input  logic [NUM_GRP-1:0]         last_len_en,
  input  logic [NUM_GRP-1:0]         tail_en,
  input  logic [NUM_GRP*POS_W-1:0]   tail_pos,
  input  logic [NUM_GRP*SEL_W-1:0]   pat_sel,
  input  logic [NUM_GRP*REP_W-1:0]   rep_cnt,
  input  logic [MODE_W-1:0]          merge_mode,
  input  logic                       pat_wr_en,
  input  logic [SEL_W-1:0]           pat_wr_addr,
  input  logic [POS_W-1:0]           pat_wr_tog_a,
  input  logic [POS_W-1:0]           pat_wr_tog_b,
  output logic [NUM_OUT-1:0]         vclk_out,
  output logic                       seq_done
);

  localparam int NUM_TOG = 2 * NUM_GRP;

  logic                       seq_active;
  logic                       arm;
  logic                       merge;
  logic [NUM_GRP*POS_W-1:0]   tog_a;
  logic [NUM_GRP*POS_W-1:0]   tog_b;
  logic [NUM_TOG*POS_W-1:0]   tog_all;
  logic [NUM_GRP-1:0]         eng_toggle;
  logic [NUM_GRP-1:0]         eng_fin;

  assign merge = (merge_mode == MODE_W'(MERGE_CODE));
  assign arm   = seq_start || (line_start && seq_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seq_active <= 1'b0;
    else if (seq_start) seq_active <= 1'b1;
  end

  vseq_pattern_store #(
    .NUM_PAT (NUM_PAT),
    .POS_W   (POS_W),
    .NUM_RD  (NUM_GRP)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pat_wr_en),
    .wr_addr  (pat_wr_addr),
    .wr_tog_a (pat_wr_tog_a),
    .wr_tog_b (pat_wr_tog_b),
    .rd_sel   (pat_sel),
    .rd_tog_a (tog_a),
    .rd_tog_b (tog_b)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_eng
    logic [REP_W-1:0]   rep_in;
    logic [NUM_TOG-1:0] use_mask;

    assign tog_all[(2*g)*POS_W   +: POS_W] = tog_a[g*POS_W +: POS_W];
    assign tog_all[(2*g+1)*POS_W +: POS_W] = tog_b[g*POS_W +: POS_W];

    if (g == 0) begin : g_lead
      assign rep_in   = rep_cnt[g*REP_W +: REP_W];
      assign use_mask = merge ? '1 : NUM_TOG'(3);
    end else begin : g_side
      assign rep_in   = merge ? '0 : rep_cnt[g*REP_W +: REP_W];
      assign use_mask = NUM_TOG'(3) << (2*g);
    end

    vseq_group_engine #(
      .POS_W   (POS_W),
      .REP_W   (REP_W),
      .NUM_TOG (NUM_TOG)
    ) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (arm),
      .rep_cnt     (rep_in),
      .start_pos   (start_pos[g*POS_W +: POS_W]),
      .pat_len     (pat_len[g*POS_W +: POS_W]),
      .last_len    (last_len[g*POS_W +: POS_W]),
      .last_len_en (last_len_en[g]),
      .tail_en     (tail_en[g]),
      .tail_pos    (tail_pos[g*POS_W +: POS_W]),
      .pix_cnt     (pix_cnt),
      .tog_pos     (tog_all),
      .tog_use     (use_mask),
      .toggle      (eng_toggle[g]),
      .finished    (eng_fin[g])
    );
  end

  vseq_output_map #(
    .NUM_OUT (NUM_OUT),
    .NUM_GRP (NUM_GRP)
  ) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (seq_start),
    .merge      (merge),
    .grp_sel    ({grp_map_hi, grp_map_lo}),
    .start_pol  (start_pol),
    .grp_toggle (eng_toggle),
    .level      (vclk_out)
  );

  assign seq_done = seq_active && (&eng_fin);

endmodule

// File: rtl/vseq_clock_sequencer_checker.sv
module vseq_clock_sequencer_checker #(
  parameter int NUM_OUT = 24,
  parameter int NUM_GRP = 4,
  parameter int REP_W   = 13,
  parameter int MODE_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       line_start,
  input logic                       seq_start,
  input logic                       seq_active,
  input logic [NUM_GRP*NUM_OUT-1:0] start_pol,
  input logic [NUM_GRP*REP_W-1:0]   rep_cnt,
  input logic [MODE_W-1:0]          merge_mode,
  input logic [NUM_OUT-1:0]         vclk_out,
  input logic                       seq_done
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (vclk_out == '0 && !seq_done));

  assert_idle_line_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !seq_active && !seq_start) |=> $stable(vclk_out));

  assert_merge_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && merge_mode == MODE_W'(1)) |=> (vclk_out == $past(start_pol[NUM_OUT-1:0])));

  assert_zero_reps_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && rep_cnt == '0) |=> seq_done);

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !seq_start) |=> $stable(vclk_out));

  assert_done_falls_on_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_done) |-> $past(seq_start || line_start));

endmodule

bind vseq_clock_sequencer vseq_clock_sequencer_checker #(
  .NUM_OUT (NUM_OUT),
  .NUM_GRP (NUM_GRP),
  .REP_W   (REP_W),
  .MODE_W  (MODE_W)
) u_vseq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .seq_start  (seq_start),
  .seq_active (seq_active),
  .start_pol  (start_pol),
  .rep_cnt    (rep_cnt),
  .merge_mode (merge_mode),
  .vclk_out   (vclk_out),
  .seq_done   (seq_done)
);

// File: tb/vseq_clock_sequencer_test.sv
module vseq_clock_sequencer_test;
  localparam int NO = 24;
  localparam int NG = 4;
  localparam int PW = 13;
  localparam int RW = 13;
  localparam int NP = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] pix_cnt = '0;
  logic line_start = 1'b0, seq_start = 1'b0;
  logic [23:0] grp_map_lo = '0, grp_map_hi = '0;
  logic [NG*NO-1:0] start_pol = '0;
  logic [NG*PW-1:0] start_pos = '0, pat_len = '0, last_len = '0, tail_pos = '0;
  logic [NG-1:0] last_len_en = '0, tail_en = '0;
  logic [NG*SW-1:0] pat_sel = '0;
  logic [NG*RW-1:0] rep_cnt = '0;
  logic [3:0] merge_mode = '0;
  logic pat_wr_en = 1'b0;
  logic [SW-1:0] pat_wr_addr = '0;
  logic [PW-1:0] pat_wr_tog_a = '0, pat_wr_tog_b = '0;
  logic [NO-1:0] vclk_out;
  logic seq_done;

  vseq_clock_sequencer uut (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_start(line_start),
    .seq_start(seq_start), .grp_map_lo(grp_map_lo), .grp_map_hi(grp_map_hi),
    .start_pol(start_pol), .start_pos(start_pos), .pat_len(pat_len),
    .last_len(last_len), .last_len_en(last_len_en), .tail_en(tail_en),
    .tail_pos(tail_pos), .pat_sel(pat_sel), .rep_cnt(rep_cnt),
    .merge_mode(merge_mode), .pat_wr_en(pat_wr_en), .pat_wr_addr(pat_wr_addr),
    .pat_wr_tog_a(pat_wr_tog_a), .pat_wr_tog_b(pat_wr_tog_b),
    .vclk_out(vclk_out), .seq_done(seq_done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0, chk_on = 0;
  string tag = "R1";

  // Reference model: 0 idle, 1 waiting, 2 running, 3 closing, 4 finished
  int st[NG], mpos[NG], mri[NG], mrn[NG];
  int pa[NP], pb[NP];
  logic [NO-1:0] m_out = '0;
  bit m_act = 0, m_done = 0, m_merge;
  bit tg[NG];

  function automatic int gf(logic [NG*PW-1:0] v, int g);
    return int'(v[g*PW +: PW]);
  endfunction

  function automatic int map_of(int i);
    if (i < 12) return int'(grp_map_lo[2*i +: 2]);
    return int'(grp_map_hi[2*(i-12) +: 2]);
  endfunction

  initial begin
    for (int g = 0; g < NG; g++) begin st[g] = 0; mpos[g] = 0; mri[g] = 0; mrn[g] = 0; end
    for (int e = 0; e < NP; e++) begin pa[e] = 8191; pb[e] = 8191; end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) st[g] = 0;
      for (int e = 0; e < NP; e++) begin pa[e] = 8191; pb[e] = 8191; end
      m_out = '0; m_act = 0;
    end else begin
      m_merge = (merge_mode == 4'd1);
      for (int g = 0; g < NG; g++) begin
        tg[g] = 0;
        if (st[g] == 2) begin
          for (int k = 0; k < NG; k++) begin
            int s; s = int'(pat_sel[k*SW +: SW]);
            if ((k == g || (m_merge && g == 0)) && (mpos[g] == pa[s] || mpos[g] == pb[s])) tg[g] = 1;
          end
        end
        if (st[g] == 3 && mpos[g] == gf(tail_pos, g)) tg[g] = 1;
      end
      for (int i = 0; i < NO; i++) begin
        int grp; grp = m_merge ? 0 : map_of(i);
        if (seq_start) m_out[i] = start_pol[grp*NO + i];
        else if (tg[grp]) m_out[i] = ~m_out[i];
      end
      for (int g = 0; g < NG; g++) begin
        if (seq_start || (line_start && m_act)) begin
          mrn[g] = (m_merge && g > 0) ? 0 : int'(rep_cnt[g*RW +: RW]);
          st[g] = (mrn[g] == 0) ? 4 : 1; mpos[g] = 0; mri[g] = 0;
        end else if (st[g] == 1) begin
          if (int'(pix_cnt) == gf(start_pos, g)) begin st[g] = 2; mpos[g] = 0; end
        end else if (st[g] == 2) begin
          int len;
          len = (last_len_en[g] && mri[g] == mrn[g]-1) ? gf(last_len, g) : gf(pat_len, g);
          if (mpos[g] + 1 >= len) begin
            mpos[g] = 0;
            if (mri[g] == mrn[g]-1) st[g] = tail_en[g] ? 3 : 4;
            else mri[g]++;
          end else mpos[g]++;
        end else if (st[g] == 3) begin
          if (mpos[g] == gf(tail_pos, g)) st[g] = 4; else mpos[g]++;
        end
      end
      if (seq_start) m_act = 1;
      if (pat_wr_en) begin pa[pat_wr_addr] = int'(pat_wr_tog_a); pb[pat_wr_addr] = int'(pat_wr_tog_b); end
    end
    m_done = m_act && st[0] == 4 && st[1] == 4 && st[2] == 4 && st[3] == 4;
  end

  always @(negedge clk) begin
    if (chk_on && !finished) begin
      n_chk++;
      if (vclk_out !== m_out || seq_done !== m_done) begin
        n_fail++;
        $display("FAIL %s: vclk_out=%h seq_done=%b expected %h %b", tag, vclk_out, seq_done, m_out, m_done);
      end
    end
  end

  task automatic check(string req, logic [NO-1:0] got, logic [NO-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr_pat(int a, int ta, int tb);
    pat_wr_en = 1; pat_wr_addr = SW'(a); pat_wr_tog_a = PW'(ta); pat_wr_tog_b = PW'(tb);
    @(negedge clk); pat_wr_en = 0;
  endtask

  task automatic set_grp(int g, int sp, int len, int ll, int rep, int tp, int sel);
    start_pos[g*PW +: PW] = PW'(sp); pat_len[g*PW +: PW] = PW'(len);
    last_len[g*PW +: PW] = PW'(ll); rep_cnt[g*RW +: RW] = RW'(rep);
    tail_pos[g*PW +: PW] = PW'(tp); pat_sel[g*SW +: SW] = SW'(sel);
  endtask

  task automatic pulse_seq();
    seq_start = 1; pix_cnt = '0; @(negedge clk); seq_start = 0;
  endtask

  task automatic pulse_line();
    line_start = 1; pix_cnt = '0; @(negedge clk); line_start = 0;
  endtask

  task automatic run_pix(int n);
    for (int k = 1; k <= n; k++) begin pix_cnt = PW'(k); @(negedge clk); end
  endtask

  function automatic logic [NO-1:0] pol_expect();
    logic [NO-1:0] r;
    for (int i = 0; i < NO; i++) r[i] = start_pol[map_of(i)*NO + i];
    return r;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8: watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk); chk_on = 1;
    @(negedge clk);
    check("R1", {vclk_out[NO-2:0], seq_done}, '0);
    rst_n = 1; @(negedge clk);
    check("R1", {vclk_out[NO-2:0], seq_done}, '0);

    tag = "R10";
    wr_pat(0, 2, 5); wr_pat(1, 1, 3); wr_pat(2, 0, 4); wr_pat(3, 6, 7); wr_pat(9, 3, 8191);

    tag = "R9";
    pulse_line(); run_pix(4);
    check("R9", vclk_out, '0);

    // Mixed map, distinct polarities
    for (int i = 0; i < 12; i++) begin
      grp_map_lo[2*i +: 2] = 2'(i % 4);
      grp_map_hi[2*i +: 2] = 2'((i * 3 + 1) % 4);
    end
    start_pol = 96'h5A5A5A_C3C3C3_0F0F0F_A1B2C3;
    set_grp(0, 3, 8, 4, 2, 2, 0);
    set_grp(1, 5, 6, 3, 3, 0, 1);
    set_grp(2, 2, 10, 0, 1, 5, 2);
    set_grp(3, 7, 5, 2, 2, 1, 3);

    tag = "R2";
    pulse_seq();
    check("R2", vclk_out, pol_expect());
    tag = "R3";
    run_pix(60);
    check("R8", {23'd0, seq_done}, 24'd1);

    tag = "R4";
    last_len_en = 4'b0101; tail_en = 4'b1010;
    pulse_seq(); run_pix(50);
    tag = "R5";
    last_len_en = 4'b1110; tail_en = 4'b0101;
    pulse_seq(); run_pix(50);

    tag = "R9";
    rep_cnt = {13'd1, 13'd2, 13'd1, 13'd3};
    pulse_line();
    check("R8", {23'd0, seq_done}, 24'd0);
    run_pix(50);

    tag = "R10";
    wr_pat(1, 0, 2);
    pulse_line(); run_pix(40);

    tag = "R6";
    rep_cnt = '0;
    pulse_seq();
    check("R6", vclk_out, pol_expect());
    check("R6", {23'd0, seq_done}, 24'd1);
    run_pix(20);
    check("R6", vclk_out, pol_expect());

    tag = "R7";
    merge_mode = 4'd1; last_len_en = 4'b0000; tail_en = 4'b0001;
    set_grp(0, 2, 9, 4, 3, 3, 0);
    rep_cnt[NG*RW-1:RW] = {13'd2, 13'd2, 13'd2};
    pulse_seq();
    check("R7", vclk_out, start_pol[NO-1:0]);
    run_pix(50);
    check("R8", {23'd0, seq_done}, 24'd1);

    tag = "R7";
    merge_mode = 4'd2; pulse_seq(); run_pix(50);
    merge_mode = 4'd15; pulse_seq(); run_pix(50);

    tag = "R8";
    pulse_line(); run_pix(50);
    check("R8", {23'd0, seq_done}, 24'd1);

    finish_run();
  end

endmodule